// File: doc/BRIEF.md
# Converter serial output sequencer

This block sequences the digital side of a 16-bit successive-approximation converter. It runs from the master clock. It moves the result word onto a serial data line and produces the matching serial clock and frame signals. In the self-timed modes it also decides when a conversion starts. Two static strap pins choose one of three operating modes, and all three modes share one shift register. A small converter stub outside the block delivers the result word.

In the external-clock burst mode, the converter stub presents a finished word with a one-cycle valid strobe. The host then reads the word with its own serial clock while the track input is held low. A falling edge on the hold input starts a new conversion and wipes any bits that have not been read yet.

In the self-clocked mode, a falling edge on the hold input starts a conversion. The block drives its serial clock at one quarter of the master clock rate, giving sixteen low pulses, and a frame strobe encloses the transfer. The free-running mode produces the same waveforms but starts a conversion every fixed number of master clocks. In that mode the hold input is ignored and a channel-select output alternates between the two channels.

The state machine has four states:
- `ST_CAL` is the calibration wait that follows reset.
- `ST_IDLE` waits for a start event or for a burst word.
- `ST_SHIFT` runs a self-clocked transfer.
- `ST_BURST` holds a burst word while the host reads it.

Its transitions are:
- `ST_CAL`→`ST_IDLE` when the calibration timer expires.
- `ST_IDLE`→`ST_SHIFT` on a synchronised hold fall in the self-clocked mode, or on a free-run tick in the free-running mode.
- `ST_IDLE`→`ST_BURST` when `res_valid` is seen in the burst mode.
- `ST_SHIFT`→`ST_IDLE` after the last quarter of the last bit.
- `ST_BURST`→`ST_IDLE` on a hold fall, or after the last bit has been clocked out.

A hold fall seen in `ST_IDLE` while in the burst mode clears the shift register and starts a conversion, and the state stays `ST_IDLE`.

Top module: `ser_out_seq`

## Requirements
- R1: The straps select the mode. `mode_sck`=1 with `mode_out`=0 selects burst, and `sclk_oe` is then 0. `mode_sck`=0 with `mode_out`=1 selects self-clocked, and `mode_sck`=0 with `mode_out`=0 selects free-running; in both of these `sclk_oe` is 1.
- R2: In burst mode, a `res_valid` pulse loads `res_word` and `sdata` shows bit 15 at once. Each synchronised falling edge of `sclk_in` while `trk_n` is low moves `sdata` to the next lower bit, so the word leaves MSB first. A falling edge of `sclk_in` while `trk_n` is high leaves `sdata` unchanged.
- R3: In burst mode, a falling edge on `hold_n` pulses `conv_start` once and clears the buffer. `sdata` then reads 0, including after further `sclk_in` pulses.
- R4: In self-clocked mode, a falling edge on `hold_n` in idle starts one conversion. `sclk_out` then gives exactly 16 low pulses, each 2 clocks low and 2 clocks high. `sdata` changes on the falling edges and carries the word MSB first.
- R5: `frame_n` falls in the same clock cycle as the first falling edge of `sclk_out`. It rises 2 clock cycles after the last rising edge of `sclk_out`.
- R6: Whenever no transfer is in progress, `sclk_out` and `frame_n` are both 1.
- R7: In self-clocked mode, a falling edge on `hold_n` during a transfer starts no new conversion.
- R8: In free-running mode, `conv_start` pulses every `FREE_PERIOD` (default 80) clocks and each pulse is followed by a full frame. `hold_n` has no effect.
- R9: In free-running mode, `chan_sel` toggles in the cycle `conv_start` is high, with 0 meaning channel 1 and 1 meaning channel 2. It reads 0 after reset, so the first conversion sets it to 1.
- R10: While `rst_n` is low, all state clears, `sclk_out` and `frame_n` are 1, and `busy` is 1. After `rst_n` rises, `busy` stays 1 for exactly `CAL_CYCLES` clocks (default 11,528,160). No conversion starts during that time.
- R11: In the self-timed modes, the transferred word is the value on `res_word` at the clock edge that raises `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; its release begins calibration |
| mode_sck | input | 1 | Static mode strap, serial-clock source |
| mode_out | input | 1 | Static mode strap, output timing |
| hold_n | input | 1 | Hold/start input; a falling edge is the event |
| trk_n | input | 1 | Track input; low enables burst readout |
| sclk_in | input | 1 | External serial clock in burst mode |
| res_word | input | 16 | Result word from the converter stub |
| res_valid | input | 1 | One-cycle strobe: `res_word` is ready (burst) |
| sclk_out | output | 1 | Generated serial clock, high at rest |
| sclk_oe | output | 1 | 1 when the block drives the serial clock |
| sdata | output | 1 | Serial data, MSB first |
| frame_n | output | 1 | Active-low frame strobe |
| chan_sel | output | 1 | Channel select (0 = ch1, 1 = ch2) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Calibration in progress |

## Verification
Self-clocked transfers are driven with alternating, single-LSB, single-MSB, all-ones and all-zero words. These separate a correct MSB-first order from reversed or stuck bit paths, and they test that the frame encloses the transfer at both ends. A second hold edge inside a running frame checks that a start is refused mid-transfer. A free-running sequence with a new word every conversion and a toggling hold input checks the period, the channel alternation and the word sampling edge. Burst reads check the gating by the track input with a word whose two top bits differ, and the mid-word wipe with an all-ones word, so any leftover bit would show.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

    typedef enum logic [1:0] {
        MODE_BURST,
        MODE_SELF,
        MODE_FREE,
        MODE_NONE
    } mode_t;

    typedef enum logic [1:0] {
        ST_CAL,
        ST_IDLE,
        ST_SHIFT,
        ST_BURST
    } state_t;

    typedef enum logic [2:0] {
        OP_KEEP,
        OP_TICK,
        OP_LOAD,
        OP_SHIFT,
        OP_CLEAR
    } op_t;

    function automatic mode_t decode_mode(input logic sck_strap, input logic out_strap);
        mode_t m;
        unique case ({sck_strap, out_strap})
            2'b10:   m = MODE_BURST;
            2'b01:   m = MODE_SELF;
            2'b00:   m = MODE_FREE;
            default: m = MODE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fell
);
    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
            prev_q <= RESET_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl  = stage_q[STAGES-1];
    assign fell = prev_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
    parameter int LIMIT = 11528160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT) + 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + CW'(1);
    end

    assign done = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/frun_timer.sv
module frun_timer #(
    parameter int PERIOD = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(PERIOD) + 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!run)                      cnt_q <= '0;
        else if (cnt_q == CW'(PERIOD - 1))  cnt_q <= '0;
        else                                cnt_q <= cnt_q + CW'(1);
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/ser_out_seq.sv
module ser_out_seq
    import ser_out_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SCLK_DIV    = 4,
    parameter int FREE_PERIOD = 80,
    parameter int CAL_CYCLES  = 11528160,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sck,
    input  logic             mode_out,
    input  logic             hold_n,
    input  logic             trk_n,
    input  logic             sclk_in,
    input  logic [WIDTH-1:0] res_word,
    input  logic             res_valid,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             sdata,
    output logic             frame_n,
    output logic             chan_sel,
    output logic             conv_start,
    output logic             busy
);
    localparam int PW = $clog2(SCLK_DIV);
    localparam int BW = $clog2(WIDTH);
    localparam logic [PW-1:0] PH_LAST  = PW'(SCLK_DIV - 1);
    localparam logic [PW-1:0] PH_HALF  = PW'(SCLK_DIV / 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(WIDTH - 1);

    state_t            state_q, state_d;
    op_t               op;
    mode_t             mode;
    logic              start_d, tog;
    logic [WIDTH-1:0]  shreg_q;
    logic [PW-1:0]     ph_q;
    logic [BW-1:0]     bit_q;
    logic              chan_q, start_q;
    logic              cal_done, frun_tick;
    logic [2:0]        sync_lvl, sync_fell;
    logic              hold_fall, sclk_fall, trk_low;
    logic              sync_unused;

    assign mode = decode_mode(mode_sck, mode_out);

    sync_bank #(
        .N(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b111)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({trk_n, sclk_in, hold_n}),
        .lvl  (sync_lvl),
        .fell (sync_fell)
    );

    assign hold_fall   = sync_fell[0];
    assign sclk_fall   = sync_fell[1];
    assign trk_low     = !sync_lvl[2];
    assign sync_unused = ^{sync_lvl[1:0], sync_fell[2]};

    cal_timer #(.LIMIT(CAL_CYCLES)) u_cal (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_CAL),
        .done (cal_done)
    );

    frun_timer #(.PERIOD(FREE_PERIOD)) u_frun (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state_q != ST_CAL) && (mode == MODE_FREE)),
        .tick (frun_tick)
    );

    // next-state and datapath control
    always_comb begin
        state_d = state_q;
        op      = OP_KEEP;
        start_d = 1'b0;
        tog     = 1'b0;
        unique case (state_q)
            ST_CAL: begin
                if (cal_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                unique case (mode)
                    MODE_BURST: begin
                        if (hold_fall) begin
                            op      = OP_CLEAR;
                            start_d = 1'b1;
                        end else if (res_valid) begin
                            op      = OP_LOAD;
                            state_d = ST_BURST;
                        end
                    end
                    MODE_SELF: begin
                        if (hold_fall) begin
                            op      = OP_LOAD;
                            start_d = 1'b1;
                            state_d = ST_SHIFT;
                        end
                    end
                    MODE_FREE: begin
                        if (frun_tick) begin
                            op      = OP_LOAD;
                            start_d = 1'b1;
                            tog     = 1'b1;
                            state_d = ST_SHIFT;
                        end
                    end
                    MODE_NONE: begin
                        state_d = ST_IDLE;
                    end
                endcase
            end
            ST_SHIFT: begin
                if (ph_q == PH_LAST) begin
                    op = OP_SHIFT;
                    if (bit_q == BIT_LAST) state_d = ST_IDLE;
                end else begin
                    op = OP_TICK;
                end
            end
            ST_BURST: begin
                if (hold_fall) begin
                    op      = OP_CLEAR;
                    start_d = 1'b1;
                    state_d = ST_IDLE;
                end else if (res_valid) begin
                    op = OP_LOAD;
                end else if (sclk_fall && trk_low) begin
                    op = OP_SHIFT;
                    if (bit_q == BIT_LAST) state_d = ST_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CAL;
        else        state_q <= state_d;
    end

    // shift register, phase and bit counters, channel, start pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            ph_q    <= '0;
            bit_q   <= '0;
            chan_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
            if (tog) chan_q <= ~chan_q;
            unique case (op)
                OP_KEEP: begin
                    ph_q <= ph_q;
                end
                OP_TICK: begin
                    ph_q <= ph_q + PW'(1);
                end
                OP_LOAD: begin
                    shreg_q <= res_word;
                    ph_q    <= '0;
                    bit_q   <= '0;
                end
                OP_SHIFT: begin
                    shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
                    ph_q    <= '0;
                    bit_q   <= bit_q + BW'(1);
                end
                OP_CLEAR: begin
                    shreg_q <= '0;
                    ph_q    <= '0;
                    bit_q   <= '0;
                end
                default: begin
                    ph_q <= ph_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk_out   = 1'b1;
        frame_n    = 1'b1;
        sclk_oe    = (mode == MODE_SELF) || (mode == MODE_FREE);
        sdata      = shreg_q[WIDTH-1];
        busy       = (state_q == ST_CAL);
        conv_start = start_q;
        chan_sel   = chan_q;
        if (state_q == ST_SHIFT) begin
            frame_n  = 1'b0;
            sclk_out = (ph_q >= PH_HALF);
        end
    end
endmodule

// File: rtl/ser_out_seq_chk.sv
module ser_out_seq_chk #(
    parameter int FREE_PERIOD = 80
) (
    input logic clk,
    input logic rst_n,
    input logic mode_sck,
    input logic mode_out,
    input logic sclk_out,
    input logic sclk_oe,
    input logic frame_n,
    input logic conv_start,
    input logic chan_sel,
    input logic busy
);
    logic free_m;
    logic seen_q;
    int   gap_q;

    assign free_m = !mode_sck && !mode_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (conv_start) begin
            gap_q  <= 0;
            seen_q <= free_m;
        end else if (gap_q <= FREE_PERIOD) begin
            gap_q  <= gap_q + 1;
        end
    end

    AST_BURST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sck && !mode_out) |-> !sclk_oe); // R1

    AST_FRAME_WITH_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $fell(sclk_out)); // R5

    AST_FRAME_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> ($past(sclk_out, 1) && $past(sclk_out, 2) && !$past(sclk_out, 3))); // R5

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |-> sclk_out); // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !mode_sck) |-> (!frame_n && $past(frame_n))); // R7

    AST_FREE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && free_m && seen_q) |-> (gap_q == FREE_PERIOD - 1)); // R8

    AST_CHAN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && free_m) |-> (chan_sel != $past(chan_sel))); // R9

    AST_CAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (frame_n && sclk_out && !conv_start)); // R10
endmodule

bind ser_out_seq ser_out_seq_chk #(.FREE_PERIOD(FREE_PERIOD)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sck  (mode_sck),
    .mode_out  (mode_out),
    .sclk_out  (sclk_out),
    .sclk_oe   (sclk_oe),
    .frame_n   (frame_n),
    .conv_start(conv_start),
    .chan_sel  (chan_sel),
    .busy      (busy)
);

// File: tb/ser_out_seq_tb_top.sv
`timescale 1ns/1ps
module ser_out_seq_tb_top;
    localparam int CAL = 20;
    localparam int PERIOD = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sck = 1'b0, mode_out = 1'b1;
    logic hold_n = 1'b1, trk_n = 1'b1, sclk_in = 1'b1;
    logic [15:0] res_word = 16'h0000;
    logic res_valid = 1'b0;
    logic sclk_out, sclk_oe, sdata, frame_n, chan_sel, conv_start, busy;

    int checks = 0;
    int errors = 0;
    logic [15:0] sb[$];

    always #10 clk = ~clk;

    ser_out_seq #(.CAL_CYCLES(CAL), .FREE_PERIOD(PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sck(mode_sck), .mode_out(mode_out),
        .hold_n(hold_n), .trk_n(trk_n), .sclk_in(sclk_in),
        .res_word(res_word), .res_valid(res_valid),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata(sdata),
        .frame_n(frame_n), .chan_sel(chan_sel), .conv_start(conv_start), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    bit free_phase = 1'b0;
    int nconv = 0;
    int cyc = 0, last_start = 0;
    bit have_last = 1'b0, exp_chan = 1'b0;
    bit prev_sclk = 1'b1, prev_frame = 1'b1, in_frame = 1'b0;
    int bits = 0, low_run = 0, since_rise = 0;
    logic [15:0] word = 16'h0;
    logic [15:0] exp_w;

    always @(negedge clk) begin
        if (!rst_n) begin
            have_last = 1'b0; exp_chan = 1'b0; prev_sclk = 1'b1; prev_frame = 1'b1;
            in_frame = 1'b0; bits = 0;
        end else begin
            cyc++;
            if (conv_start) begin
                nconv++;
                if (free_phase) begin
                    if (have_last) check(cyc - last_start == PERIOD, "R8 period", cyc - last_start, PERIOD);
                    exp_chan = ~exp_chan;
                    check(chan_sel == exp_chan, "R9 chan_sel", int'(chan_sel), int'(exp_chan));
                    have_last = 1'b1;
                    last_start = cyc;
                end
            end
            if (prev_frame && !frame_n) begin
                check(prev_sclk && !sclk_out, "R5 frame fall with sclk fall", int'(sclk_out), 0);
                in_frame = 1'b1; bits = 0; word = 16'h0; low_run = 0; since_rise = 0;
            end
            if (in_frame) begin
                if (!sclk_out) low_run++;
                if (!prev_sclk && sclk_out) begin
                    check(low_run == 2, "R4 low pulse width", low_run, 2);
                    low_run = 0;
                    word = {word[14:0], sdata};
                    bits++;
                    since_rise = 0;
                end else begin
                    since_rise++;
                end
                if (!prev_frame && frame_n) begin
                    check(since_rise == 2, "R5 frame rise delay", since_rise, 2);
                    check(bits == 16, "R4 pulse count", bits, 16);
                    if (sb.size() == 0) begin
                        check(1'b0, "R11 unexpected frame", int'(word), 0);
                    end else begin
                        exp_w = sb.pop_front();
                        check(word == exp_w, "R11 frame word", int'(word), int'(exp_w));
                    end
                    in_frame = 1'b0;
                end
            end
            prev_sclk = sclk_out;
            prev_frame = frame_n;
        end
    end

    task automatic do_reset(input logic sck, input logic outm);
        int n;
        rst_n = 1'b0;
        mode_sck = sck; mode_out = outm;
        hold_n = 1'b1; trk_n = 1'b1; sclk_in = 1'b1; res_valid = 1'b0;
        sb.delete();
        repeat (3) @(negedge clk);
        check(busy && frame_n && sclk_out, "R10 reset state", {busy, frame_n, sclk_out}, 7);
        rst_n = 1'b1;
        n = 0;
        while (busy) begin
            @(negedge clk);
            n++;
        end
        check(n == CAL, "R10 calibration length", n, CAL);
    endtask

    task automatic self_conv(input logic [15:0] w);
        sb.push_back(w);
        res_word = w;
        @(negedge clk);
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        hold_n = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    task automatic burst_read(input int n, output logic [15:0] w);
        w = 16'h0;
        for (int i = 0; i < n; i++) begin
            w = {w[14:0], sdata};
            sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic burst_load(input logic [15:0] w);
        res_word = w;
        @(negedge clk);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] got;
        int n0;
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] got;
        int n0;
        // self-clocked mode
        do_reset(1'b0, 1'b1);
        check(sclk_oe == 1'b1, "R1 self mode drives sclk", int'(sclk_oe), 1);
        check(frame_n && sclk_out, "R6 idle after calibration", {frame_n, sclk_out}, 3);
        self_conv(16'hA5C3);
        self_conv(16'h0001);
        self_conv(16'h8000);
        self_conv(16'hFFFF);
        self_conv(16'h0000);
        check(sb.size() == 0, "R4 all frames produced", sb.size(), 0);
        check(frame_n && sclk_out, "R6 idle between conversions", {frame_n, sclk_out}, 3);
        // R7: second hold edge during a transfer
        n0 = nconv;
        sb.push_back(16'h3C96);
        res_word = 16'h3C96;
        @(negedge clk);
        hold_n = 1'b0;
        repeat (30) @(negedge clk);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        hold_n = 1'b1;
        repeat (80) @(negedge clk);
        check(nconv == n0 + 1, "R7 start ignored mid-frame", nconv - n0, 1);
        check(sb.size() == 0, "R7 single frame", sb.size(), 0);

        // free-running mode
        res_word = 16'h1234;
        do_reset(1'b0, 1'b0);
        check(sclk_oe == 1'b1, "R1 free mode drives sclk", int'(sclk_oe), 1);
        check(chan_sel == 1'b0, "R9 channel after reset", int'(chan_sel), 0);
        free_phase = 1'b1;
        n0 = nconv;
        for (int k = 0; k < 5; k++) begin
            do @(negedge clk); while (!conv_start);
            sb.push_back(res_word);
            res_word = res_word + 16'h3B71;
            hold_n = ~hold_n;
        end
        repeat (72) @(negedge clk);
        check(nconv == n0 + 5, "R8 conversions counted", nconv - n0, 5);
        check(sb.size() == 0, "R8 every start framed", sb.size(), 0);
        free_phase = 1'b0;

        // burst mode
        do_reset(1'b1, 1'b0);
        check(sclk_oe == 1'b0, "R1 burst mode sclk input", int'(sclk_oe), 0);
        burst_load(16'h5A3C);
        check(sdata == 1'b0, "R2 MSB after load", int'(sdata), 0);
        burst_read(1, got);
        check(sdata == 1'b0, "R2 no shift while track high", int'(sdata), 0);
        trk_n = 1'b0;
        repeat (4) @(negedge clk);
        burst_read(16, got);
        check(got == 16'h5A3C, "R2 burst word", int'(got), 16'h5A3C);
        trk_n = 1'b1;
        repeat (4) @(negedge clk);
        burst_load(16'hFFFF);
        trk_n = 1'b0;
        repeat (4) @(negedge clk);
        burst_read(4, got);
        check(got[3:0] == 4'hF, "R2 partial read", int'(got[3:0]), 15);
        n0 = nconv;
        hold_n = 1'b0;
        repeat (8) @(negedge clk);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        check(nconv == n0 + 1, "R3 hold starts conversion", nconv - n0, 1);
        check(sdata == 1'b0, "R3 buffer cleared", int'(sdata), 0);
        burst_read(4, got);
        check(got[3:0] == 4'h0, "R3 discarded bits", int'(got[3:0]), 0);
        check(frame_n && sclk_out, "R6 idle in burst mode", {frame_n, sclk_out}, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule